// File: doc/BRIEF.md
# Parity-Banked Colour Cube Vertex Store

This block holds the grid of vertices of a three-dimensional colour lookup cube. A pixel arrives as three grid coordinates, the high-order bits of its red, green and blue components. The block returns all eight corners of the sub-cube that encloses that pixel in one access. A downstream interpolator then blends the eight corners with the low-order bits, which never enter this block. The grid has 2^M+1 points per axis, so the top sub-cube on each axis still has its upper corners.

The vertices are split across eight sub-memories by the parity of their grid coordinates. The eight corners of any sub-cube therefore fall in eight different sub-memories and are read in the same cycle. A crossbar after the memories puts each corner in a fixed output slot, whatever the parity of the base corner.

Each sub-memory holds two pages: the second page sits at a fixed address offset above the first. A simple host port writes any vertex of either page and requests which page is active. The request waits until the first pixel of the next frame, and that pixel already uses the new page. Frame mid-points never see a page change.

Top module: `lut3d_vertex_mem`

## Requirements
- R1: `out_valid` and `out_sof` repeat `px_valid` and `px_valid && px_sof` exactly two clock cycles later. Pixels may arrive on back-to-back cycles.
- R2: For an accepted pixel with grid coordinates (r,g,b), output slot j = 4*dr+2*dg+db (dr,dg,db in {0,1}) on bits `out_vertex[j*DATA_W +: DATA_W]` carries the vertex at (r+dr, g+dg, b+db) of the page in use for that pixel.
- R3: The slot order of R2 holds for every combination of odd and even base coordinates.
- R4: A base coordinate of 2^M-1 on any axis returns the grid point 2^M on that axis as its upper corner.
- R5: A host write with `host_wr_en` high stores `host_wr_data` at vertex index (r*N+g)*N+b, with N = 2^M+1, in the page given by `host_wr_page`.
- R6: A host write whose index is N^3 or more changes no vertex in either page.
- R7: A page requested with `host_sel_en` becomes active on the first later pixel that has `px_valid` and `px_sof` high, including that pixel. Pixels before it keep the old page.
- R8: After reset the active page and the requested page are 0, `out_valid` and `out_sof` are low, and `out_vertex` is all zeros.
- R9: A write to the page that is not active does not change what pixels read from the active page.
- R10: When several page requests arrive before a frame start, the last one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Pixel coordinates valid this cycle |
| px_sof | input | 1 | Pixel is the first of a frame |
| px_r | input | M (3) | Red grid coordinate (high-order bits) |
| px_g | input | M (3) | Green grid coordinate |
| px_b | input | M (3) | Blue grid coordinate |
| host_wr_en | input | 1 | Vertex write strobe |
| host_wr_page | input | 1 | Page that the vertex write targets |
| host_wr_index | input | 10 | Linear vertex index (r*N+g)*N+b |
| host_wr_data | input | DATA_W (24) | Vertex value to store |
| host_sel_en | input | 1 | Active-page request strobe |
| host_sel_page | input | 1 | Requested active page |
| out_valid | output | 1 | Corner set valid |
| out_sof | output | 1 | Corner set belongs to a frame's first pixel |
| out_vertex | output | 8*DATA_W (192) | Eight corners, slot j at bits j*DATA_W |

## Verification
An error in the parity crossbar shows up as swapped corner slots on the same pixel two cycles later. An error in the address split shows up as corners taken from a neighbouring grid point, and it appears first at odd coordinates and at the top edge of the cube. A stale or early page register shows up on the first pixel of a frame, or on a mid-frame pixel just after a request. The page values written for the test differ in their top bit, so a wrong page gives a wrong value in every slot. A write that lands in the wrong bank or page stays hidden until a pixel reads that vertex. The bench therefore reads back both pages, before and after the page swap, and reads an alias address that an unchecked out-of-range write would hit.

// File: rtl/lut3d_pkg.sv
package lut3d_pkg;

    // Corner offset / bank number: {r, g, b} bit order
    typedef logic [2:0] corner_t;

    // Tag that travels with each pixel through the read pipeline
    typedef struct packed {
        logic valid;
        logic sof;
    } px_tag_t;

    function automatic int unsigned grid_points(input int unsigned m);
        return (32'd1 << m) + 32'd1;
    endfunction

    function automatic int unsigned half_points(input int unsigned m);
        return (32'd1 << (m - 1)) + 32'd1;
    endfunction

    // Bank that owns a grid point, from the parity of its coordinates
    function automatic corner_t bank_of(input logic r0, input logic g0, input logic b0);
        return {r0, g0, b0};
    endfunction

    // Bank feeding output slot j for a base corner of the given parity
    function automatic corner_t slot_source(input corner_t slot, input corner_t base_par);
        return slot ^ base_par;
    endfunction

    // Address inside one bank: page offset plus halved-coordinate position
    function automatic int unsigned vtx_addr(
        input int unsigned page,
        input int unsigned hr,
        input int unsigned hg,
        input int unsigned hb,
        input int unsigned h,
        input int unsigned page_depth
    );
        return page * page_depth + (hr * h + hg) * h + hb;
    endfunction

endpackage

// File: rtl/lut3d_page_ctrl.sv
module lut3d_page_ctrl #(
    parameter bit DOUBLE_BUF = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_en,
    input  logic sel_page,
    input  logic px_valid,
    input  logic px_sof,
    output logic page_now
);
    logic frame_start;
    assign frame_start = px_valid && px_sof;

    generate
        if (DOUBLE_BUF) begin : g_two_pages
            logic pend_q;
            logic active_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q   <= 1'b0;
                    active_q <= 1'b0;
                end else begin
                    if (sel_en) begin
                        pend_q <= sel_page;
                    end
                    if (frame_start) begin
                        active_q <= pend_q;
                    end
                end
            end

            // The frame's first pixel already reads the requested page
            assign page_now = frame_start ? pend_q : active_q;

            // R7: the active page never moves in the middle of a frame
            a_r7_hold_midframe: assert property (@(posedge clk) disable iff (rst)
                !frame_start |=> $stable(active_q));

            // R7: a frame start loads the page that was pending
            a_r7_load_pending: assert property (@(posedge clk) disable iff (rst)
                frame_start |=> active_q == $past(pend_q));

            // R8: both page registers clear on reset
            a_r8_pages_clear: assert property (@(posedge clk)
                rst |=> (!active_q && !pend_q));
        end else begin : g_one_page
            logic unused_in;
            assign unused_in = &{1'b0, clk, rst, sel_en, sel_page, frame_start};
            assign page_now  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/lut3d_wr_route.sv
module lut3d_wr_route
    import lut3d_pkg::*;
#(
    parameter int unsigned M          = 3,
    parameter int unsigned DATA_W     = 24,
    parameter int unsigned PAGES      = 2,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned BA_W       = 8
) (
    input  logic                    wr_en,
    input  logic                    wr_page,
    input  logic [IDX_W-1:0]        wr_index,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [7:0]              bank_we,
    output logic [BA_W-1:0]         bank_waddr,
    output logic [DATA_W-1:0]       bank_wdata
);
    localparam int unsigned N          = grid_points(M);
    localparam int unsigned H          = half_points(M);
    localparam int unsigned PAGE_DEPTH = H * H * H;
    localparam int unsigned N_VERTS    = N * N * N;

    int unsigned idx_i;
    int unsigned r_i;
    int unsigned g_i;
    int unsigned b_i;
    int unsigned page_i;
    logic        in_range;
    corner_t     bank;

    always_comb begin
        idx_i    = 32'(wr_index);
        r_i      = idx_i / (N * N);
        g_i      = (idx_i / N) % N;
        b_i      = idx_i % N;
        page_i   = (PAGES > 1) ? 32'(wr_page) : 32'd0;
        in_range = idx_i < N_VERTS;
        bank     = bank_of(r_i[0], g_i[0], b_i[0]);
        bank_we  = (wr_en && in_range) ? (8'b1 << bank) : 8'b0;
        bank_waddr = BA_W'(vtx_addr(page_i, r_i >> 1, g_i >> 1, b_i >> 1, H, PAGE_DEPTH));
        bank_wdata = wr_data;
    end

    // R5: a write goes to at most one bank
    always_comb begin
        a_r5_one_bank: assert ($onehot0(bank_we));
    end

endmodule

// File: rtl/lut3d_rd_addr.sv
module lut3d_rd_addr
    import lut3d_pkg::*;
#(
    parameter int unsigned M    = 3,
    parameter int unsigned BA_W = 8
) (
    input  logic                  page,
    input  logic [M-1:0]          r,
    input  logic [M-1:0]          g,
    input  logic [M-1:0]          b,
    output logic [7:0][BA_W-1:0]  addr,
    output corner_t               base_par
);
    localparam int unsigned H          = half_points(M);
    localparam int unsigned PAGE_DEPTH = H * H * H;

    assign base_par = bank_of(r[0], g[0], b[0]);

    generate
        for (genvar k = 0; k < 8; k++) begin : g_bank
            localparam corner_t KC = corner_t'(k);
            int unsigned cr;
            int unsigned cg;
            int unsigned cb;

            // Bank k holds the corner whose offset makes the parity equal k
            always_comb begin
                cr = 32'(r) + 32'(KC[2] ^ r[0]);
                cg = 32'(g) + 32'(KC[1] ^ g[0]);
                cb = 32'(b) + 32'(KC[0] ^ b[0]);
                addr[k] = BA_W'(vtx_addr(32'(page), cr >> 1, cg >> 1, cb >> 1,
                                         H, PAGE_DEPTH));
            end
        end
    endgenerate

endmodule

// File: rtl/lut3d_bank.sv
module lut3d_bank #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned DEPTH  = 250,
    parameter int unsigned AW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

    // R5: writes stay inside the bank
    a_r5_waddr_in_bank: assert property (@(posedge clk) disable iff (rst)
        we |-> 32'(waddr) < DEPTH);

    // R2: reads stay inside the bank
    a_r2_raddr_in_bank: assert property (@(posedge clk) disable iff (rst)
        re |-> 32'(raddr) < DEPTH);

endmodule

// File: rtl/lut3d_vertex_mem.sv
module lut3d_vertex_mem
    import lut3d_pkg::*;
#(
    parameter int unsigned M          = 3,
    parameter int unsigned DATA_W     = 24,
    parameter bit          DOUBLE_BUF = 1'b1,
    localparam int unsigned N         = grid_points(M),
    localparam int unsigned IDX_W     = $clog2(N * N * N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  px_valid,
    input  logic                  px_sof,
    input  logic [M-1:0]          px_r,
    input  logic [M-1:0]          px_g,
    input  logic [M-1:0]          px_b,
    input  logic                  host_wr_en,
    input  logic                  host_wr_page,
    input  logic [IDX_W-1:0]      host_wr_index,
    input  logic [DATA_W-1:0]     host_wr_data,
    input  logic                  host_sel_en,
    input  logic                  host_sel_page,
    output logic                  out_valid,
    output logic                  out_sof,
    output logic [8*DATA_W-1:0]   out_vertex
);
    localparam int unsigned H          = half_points(M);
    localparam int unsigned PAGES      = DOUBLE_BUF ? 2 : 1;
    localparam int unsigned BANK_DEPTH = PAGES * H * H * H;
    localparam int unsigned BA_W       = $clog2(BANK_DEPTH);

    // ---------------- page selection ----------------
    logic page_now;

    lut3d_page_ctrl #(
        .DOUBLE_BUF (DOUBLE_BUF)
    ) u_page (
        .clk      (clk),
        .rst      (rst),
        .sel_en   (host_sel_en),
        .sel_page (host_sel_page),
        .px_valid (px_valid),
        .px_sof   (px_sof),
        .page_now (page_now)
    );

    // ---------------- read address generation ----------------
    logic [7:0][BA_W-1:0] rd_addr;
    corner_t              rd_base;

    lut3d_rd_addr #(
        .M    (M),
        .BA_W (BA_W)
    ) u_rd_addr (
        .page     (page_now),
        .r        (px_r),
        .g        (px_g),
        .b        (px_b),
        .addr     (rd_addr),
        .base_par (rd_base)
    );

    // ---------------- host write routing ----------------
    logic [7:0]          wr_we;
    logic [BA_W-1:0]     wr_addr;
    logic [DATA_W-1:0]   wr_data;

    lut3d_wr_route #(
        .M      (M),
        .DATA_W (DATA_W),
        .PAGES  (PAGES),
        .IDX_W  (IDX_W),
        .BA_W   (BA_W)
    ) u_wr_route (
        .wr_en      (host_wr_en),
        .wr_page    (host_wr_page),
        .wr_index   (host_wr_index),
        .wr_data    (host_wr_data),
        .bank_we    (wr_we),
        .bank_waddr (wr_addr),
        .bank_wdata (wr_data)
    );

    // ---------------- stage 1: registered addresses ----------------
    logic [7:0][BA_W-1:0] s1_addr;
    corner_t              s1_base;
    px_tag_t              s1_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_addr <= '0;
            s1_base <= '0;
            s1_tag  <= '0;
        end else begin
            s1_tag.valid <= px_valid;
            s1_tag.sof   <= px_valid && px_sof;
            if (px_valid) begin
                s1_addr <= rd_addr;
                s1_base <= rd_base;
            end
        end
    end

    // ---------------- stage 2: bank reads ----------------
    logic [7:0][DATA_W-1:0] bank_q;
    corner_t                s2_base;
    px_tag_t                s2_tag;

    generate
        for (genvar k = 0; k < 8; k++) begin : g_mem
            lut3d_bank #(
                .DATA_W (DATA_W),
                .DEPTH  (BANK_DEPTH),
                .AW     (BA_W)
            ) u_bank (
                .clk   (clk),
                .rst   (rst),
                .we    (wr_we[k]),
                .waddr (wr_addr),
                .wdata (wr_data),
                .re    (s1_tag.valid),
                .raddr (s1_addr[k]),
                .rdata (bank_q[k])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_base <= '0;
            s2_tag  <= '0;
        end else begin
            s2_tag <= s1_tag;
            if (s1_tag.valid) begin
                s2_base <= s1_base;
            end
        end
    end

    // ---------------- output crossbar: slot j <- bank j^base ----------------
    generate
        for (genvar j = 0; j < 8; j++) begin : g_slot
            localparam corner_t JC = corner_t'(j);
            assign out_vertex[j*DATA_W +: DATA_W] = bank_q[slot_source(JC, s2_base)];
        end
    endgenerate

    assign out_valid = s2_tag.valid;
    assign out_sof   = s2_tag.sof;

    // ---------------- checks ----------------
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    // R1: valid emerges exactly two cycles after the pixel
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (out_valid == $past(px_valid, 2)));

    // R1: frame-start flag only on a valid output
    a_r1_sof_in_frame: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    // R8: outputs are quiet right after reset
    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sof && out_vertex == '0));

endmodule

// File: tb/lut3d_vertex_mem_tb.sv
`timescale 1ns/1ps
module lut3d_vertex_mem_tb;

    localparam int M      = 3;
    localparam int DATA_W = 24;
    localparam int N      = (1 << M) + 1;
    localparam int NV     = N * N * N;
    localparam int IDX_W  = $clog2(NV);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 px_valid = 1'b0;
    logic                 px_sof = 1'b0;
    logic [M-1:0]         px_r = '0;
    logic [M-1:0]         px_g = '0;
    logic [M-1:0]         px_b = '0;
    logic                 host_wr_en = 1'b0;
    logic                 host_wr_page = 1'b0;
    logic [IDX_W-1:0]     host_wr_index = '0;
    logic [DATA_W-1:0]    host_wr_data = '0;
    logic                 host_sel_en = 1'b0;
    logic                 host_sel_page = 1'b0;
    logic                 out_valid;
    logic                 out_sof;
    logic [8*DATA_W-1:0]  out_vertex;

    always #2.5 clk = ~clk;

    lut3d_vertex_mem #(.M(M), .DATA_W(DATA_W), .DOUBLE_BUF(1'b1)) u_dut (
        .clk(clk), .rst(rst),
        .px_valid(px_valid), .px_sof(px_sof),
        .px_r(px_r), .px_g(px_g), .px_b(px_b),
        .host_wr_en(host_wr_en), .host_wr_page(host_wr_page),
        .host_wr_index(host_wr_index), .host_wr_data(host_wr_data),
        .host_sel_en(host_sel_en), .host_sel_page(host_sel_page),
        .out_valid(out_valid), .out_sof(out_sof), .out_vertex(out_vertex)
    );

    int n_checks = 0;
    int n_fails  = 0;
    logic [DATA_W-1:0] model [2][NV];

    function automatic int vidx(input int r, input int g, input int b);
        return (r * N + g) * N + b;
    endfunction

    function automatic logic [DATA_W-1:0] seed(input int p, input int r, input int g, input int b);
        return {p[0], 7'(r), 8'(g), 8'(b)} ^ 24'h35_a1c3;
    endfunction

    function automatic logic [8*DATA_W-1:0] expect_set(input int p, input int r, input int g, input int b);
        logic [8*DATA_W-1:0] v;
        for (int j = 0; j < 8; j++) begin
            v[j*DATA_W +: DATA_W] = model[p][vidx(r + ((j >> 2) & 1), g + ((j >> 1) & 1), b + (j & 1))];
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [8*DATA_W-1:0] got,
                         input logic [8*DATA_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic host_write(input int p, input int idx, input logic [DATA_W-1:0] d, input bit track);
        @(negedge clk);
        host_wr_en    = 1'b1;
        host_wr_page  = p[0];
        host_wr_index = IDX_W'(idx);
        host_wr_data  = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        if (track) model[p][idx] = d;
    endtask

    task automatic host_select(input int p);
        @(negedge clk);
        host_sel_en   = 1'b1;
        host_sel_page = p[0];
        @(negedge clk);
        host_sel_en = 1'b0;
    endtask

    // One isolated pixel; checks latency, flags and the eight corners
    task automatic apply_px(input string req, input int r, input int g, input int b,
                            input bit sof, input int page);
        @(negedge clk);
        px_valid = 1'b1; px_sof = sof;
        px_r = M'(r); px_g = M'(g); px_b = M'(b);
        @(negedge clk);
        px_valid = 1'b0; px_sof = 1'b0;
        check("R1 valid not early", {191'b0, out_valid}, '0);
        @(negedge clk);
        check("R1 flags after two cycles", {190'b0, out_valid, out_sof}, {190'b0, 1'b1, sof});
        check(req, out_vertex, expect_set(page, r, g, b));
    endtask

    localparam int NVEC = 12;
    // {r, g, b} per vector, covering each base-parity class and the top edge
    localparam logic [8:0] VEC [NVEC] = '{
        {3'd0, 3'd0, 3'd0}, {3'd1, 3'd0, 3'd0}, {3'd0, 3'd1, 3'd0}, {3'd0, 3'd0, 3'd1},
        {3'd1, 3'd1, 3'd0}, {3'd1, 3'd0, 3'd1}, {3'd0, 3'd1, 3'd1}, {3'd1, 3'd1, 3'd1},
        {3'd7, 3'd7, 3'd7}, {3'd7, 3'd2, 3'd5}, {3'd6, 3'd7, 3'd3}, {3'd4, 3'd5, 3'd7}
    };

    bit done = 1'b0;
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state at the ports
        check("R8 reset outputs", {out_valid, out_sof, out_vertex}, '0);

        // R5: fill both pages through the host port
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < N; r++)
                for (int g = 0; g < N; g++)
                    for (int b = 0; b < N; b++)
                        host_write(p, vidx(r, g, b), seed(p, r, g, b), 1'b1);

        // R2 R3 R4: vector table on page 0
        for (int i = 0; i < NVEC; i++) begin
            apply_px((VEC[i][8:6] == 3'd7 || VEC[i][2:0] == 3'd7) ? "R4 top edge corners" : "R2/R3 corner order",
                     int'(VEC[i][8:6]), int'(VEC[i][5:3]), int'(VEC[i][2:0]), 1'b0, 0);
        end

        // R1: back-to-back pixels, checked two cycles after each
        for (int i = 0; i < NVEC + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R1 streaming valid", {191'b0, out_valid}, {191'b0, 1'b1});
                check("R1 streaming data", out_vertex,
                      expect_set(0, int'(VEC[i-2][8:6]), int'(VEC[i-2][5:3]), int'(VEC[i-2][2:0])));
            end
            if (i < NVEC) begin
                px_valid = 1'b1;
                px_r = VEC[i][8:6]; px_g = VEC[i][5:3]; px_b = VEC[i][2:0];
            end else begin
                px_valid = 1'b0;
            end
        end

        // R7: request page 1; mid-frame pixel stays on 0, frame start switches
        host_select(1);
        apply_px("R7 no mid-frame swap", 1, 2, 3, 1'b0, 0);
        apply_px("R7 swap on frame start", 1, 2, 3, 1'b1, 1);
        apply_px("R7 page held after start", 4, 4, 4, 1'b0, 1);

        // R6: index 810 would alias page 1 vertex (0,0,0) if not rejected
        host_write(0, 810, 24'hdead_00, 1'b0);
        host_write(1, NV, 24'hbeef_00, 1'b0);
        apply_px("R6 out-of-range write ignored", 0, 0, 0, 1'b0, 1);

        // R9: write inactive page 0 while page 1 is active
        host_write(0, vidx(2, 2, 2), 24'h0c0ffe, 1'b1);
        apply_px("R9 active page untouched", 1, 1, 1, 1'b0, 1);
        host_select(0);
        apply_px("R9 new data after swap", 1, 1, 1, 1'b1, 0);

        // R10: last request before the frame start wins
        host_select(1);
        host_select(0);
        apply_px("R10 last request wins", 2, 3, 4, 1'b1, 0);

        // R5 R4: new top-corner vertex on page 1 seen after swap
        host_write(1, vidx(8, 8, 8), 24'h7e57ab, 1'b1);
        host_select(1);
        apply_px("R5 write lands in page 1", 7, 7, 7, 1'b1, 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule